// File: doc/BRIEF.md
# MDIO Management Master with Register Front End

This block lets a host processor reach the management registers of up to three Ethernet PHYs over a two-wire MDC/MDIO bus using standard Clause 22 frames. The host sees two 32-bit words on a simple write-enable/read-mux register bus. A single write to the command word holds the operation, PHY number, register number, write data and a go bit, and it launches one bus transaction. The host then polls the go bit, which reads as busy until the frame ends. A separate status word returns the 16 bits read back and an error flag.

A small divider derives MDC from the system clock. A frame engine built around a 64-bit shift register sends the preamble and header, releases the line for turnaround on reads, and samples the PHY's answer. The register front end decodes commands, rejects PHY numbers that are out of range without touching the bus, and records the outcome when the engine reports completion.

The engine FSM has six states. `ST_IDLE` moves to `ST_PRE` on a start strobe. `ST_PRE` moves to `ST_HDR` after bit 31. `ST_HDR` moves to `ST_TA` after bit 45. `ST_TA` moves to `ST_DATA` after bit 47. `ST_DATA` moves to `ST_END` after bit 63. `ST_END` pulses done and returns to `ST_IDLE`. Each of these moves from `ST_PRE` through `ST_DATA` happens on the MDC falling-edge strobe that follows the given bit.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset both words read 0, MDC is low and the MDIO output enable is 0.
- R2: The status word is at byte offset 0x10 and the command word at 0x14. Any other offset reads 0. The command word reads back as {busy[31], 0[30:27], write-op[26], PHY[25:21], register[20:16], write data[15:0]}. The status word reads {error[31], 0[30:16], read data[15:0]}.
- R3: Writing the command word with bit 31 set and a valid PHY starts one frame. Bit 31 then reads 1 from the next cycle until the frame ends, and then reads 0. A command write with bit 31 clear has no effect.
- R4: A write (bit 26 = 1) sends, MSB first with the output enabled throughout: 32 ones, start 01, opcode 01, 5-bit PHY, 5-bit register, turnaround 10, 16 data bits.
- R5: A read (bit 26 = 0) sends 32 ones, 01, opcode 10, PHY and register. It then disables the output for the 18 turnaround and data bit times and captures 16 bits, MSB first, into status[15:0], with status[31] = 0 when the second turnaround bit is 0.
- R6: MDC stays high and low for DIV_HALF system clocks each. It is low and still while no frame runs. MDIO changes only at MDC falling edges and is sampled at rising edges.
- R7: A go write whose PHY field is 3 or more starts no MDC activity. It sets status[31] to 1, keeps status[15:0] unchanged, and leaves busy at 0.
- R8: If the PHY drives the second turnaround bit of a read as 1, status[31] becomes 1. The captured data still updates status[15:0].
- R9: A command write while busy is ignored. The frame in progress and the command readback fields stay unchanged, and no extra frame follows.
- R10: A completed write leaves status[15:0] unchanged and clears status[31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 1 | Serial data driven toward the PHYs |
| mdio_oe | output | 1 | Output enable for mdio_out |
| mdio_in | input | 1 | Serial data from the shared MDIO line |

## Verification
The hardest case to reach is a command write arriving while a frame is still on the wire. The bench issues a second go write in the cycles right after starting a read. It then confirms that the scoreboard receives exactly one frame, that this frame matches the first command, and that the readback fields never changed. A turnaround error is just as hard to reach from the ports. To produce it, the bench's PHY responder drives the second turnaround bit high on one read, and the bench then checks that a following write clears the flag while keeping the captured data.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    // register map: fixed byte offsets that software decodes
    localparam logic [7:0] STAT_OFS = 8'h10;
    localparam logic [7:0] CMD_OFS  = 8'h14;

    // command word field positions
    localparam int GO_BIT  = 31;
    localparam int OP_BIT  = 26;
    localparam int PHY_LSB = 21;
    localparam int REG_LSB = 16;
    localparam int ERR_BIT = 31;

    // frame layout, in bit times from the first preamble bit
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 64;
    localparam int PRE_LAST   = PRE_BITS - 1;
    localparam int HDR_LAST   = PRE_BITS + 14 - 1;
    localparam int TA_LAST    = HDR_LAST + 2;
    localparam int DATA_LAST  = FRAME_BITS - 1;
    localparam int BIT_CNT_W  = $clog2(FRAME_BITS);

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] wdata;
    } mdio_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA,
        ST_END
    } mdio_state_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CNT_W = $clog2(DIV_HALF + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap     = run && (cnt_q == CNT_LAST);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the clock never toggles unless a frame is running
    assert_mdc_still_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_in,
    output logic        run,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic        idle,
    output logic        done,
    output logic        ta_err,
    output logic [15:0] rx_data
);
    mdio_state_t          state_q, state_d;
    logic [FRAME_BITS-1:0] tx_q;
    logic [BIT_CNT_W-1:0]  bit_q;
    logic                  wr_q;

    localparam logic [BIT_CNT_W-1:0] B_PRE  = BIT_CNT_W'(PRE_LAST);
    localparam logic [BIT_CNT_W-1:0] B_HDR  = BIT_CNT_W'(HDR_LAST);
    localparam logic [BIT_CNT_W-1:0] B_TA   = BIT_CNT_W'(TA_LAST);
    localparam logic [BIT_CNT_W-1:0] B_DATA = BIT_CNT_W'(DATA_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)                      state_d = ST_PRE;
            ST_PRE:  if (fall_stb && bit_q == B_PRE)  state_d = ST_HDR;
            ST_HDR:  if (fall_stb && bit_q == B_HDR)  state_d = ST_TA;
            ST_TA:   if (fall_stb && bit_q == B_TA)   state_d = ST_DATA;
            ST_DATA: if (fall_stb && bit_q == B_DATA) state_d = ST_END;
            ST_END:                                   state_d = ST_IDLE;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run     = 1'b0;
        mdio_oe = 1'b0;
        idle    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: idle = 1'b1;
            ST_PRE, ST_HDR: begin
                run     = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_TA, ST_DATA: begin
                run     = 1'b1;
                mdio_oe = wr_q;
            end
            ST_END:  done = 1'b1;
            default: idle = 1'b1;
        endcase
    end

    assign mdio_out = tx_q[FRAME_BITS-1];

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            bit_q   <= '0;
            wr_q    <= 1'b0;
            ta_err  <= 1'b0;
            rx_data <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                tx_q   <= {{PRE_BITS{1'b1}}, 2'b01,
                           cmd.wr ? 2'b01 : 2'b10,
                           cmd.phy, cmd.regn,
                           cmd.wr ? 2'b10 : 2'b11,
                           cmd.wr ? cmd.wdata : 16'hFFFF};
                bit_q  <= '0;
                wr_q   <= cmd.wr;
                ta_err <= 1'b0;
            end
        end else begin
            if (fall_stb) begin
                tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b1};
                bit_q <= bit_q + 1'b1;
            end
            if (rise_stb && !wr_q) begin
                if (state_q == ST_TA && bit_q == B_TA) ta_err <= mdio_in;
                if (state_q == ST_DATA) rx_data <= {rx_data[14:0], mdio_in};
            end
        end
    end

    // R6: while a frame runs, the line moves only after a falling MDC strobe
    assert_mdio_moves_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE && !$stable(mdio_out))
        |-> $past(fall_stb));
    // R5: a read never drives the line after the header
    assert_read_releases_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !wr_q) |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_PHY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_idle,
    input  logic              eng_done,
    input  logic              eng_ta_err,
    input  logic [15:0]       eng_rx,
    output logic              start_o,
    output mdio_cmd_t         cmd_o,
    output logic              busy_o
);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    mdio_cmd_t   cmd_q;
    logic        busy_q, start_q, err_q;
    logic [15:0] rd_q;
    logic        accept, phy_ok;

    assign accept = bus_we && (bus_addr == A_CMD) && bus_wdata[GO_BIT] && !busy_q;
    assign phy_ok = int'(bus_wdata[PHY_LSB +: 5]) < NUM_PHY;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            err_q   <= 1'b0;
            rd_q    <= '0;
        end else begin
            start_q <= 1'b0;
            if (accept) begin
                if (phy_ok) begin
                    cmd_q.wr    <= bus_wdata[OP_BIT];
                    cmd_q.phy   <= bus_wdata[PHY_LSB +: 5];
                    cmd_q.regn  <= bus_wdata[REG_LSB +: 5];
                    cmd_q.wdata <= bus_wdata[15:0];
                    busy_q      <= 1'b1;
                    start_q     <= 1'b1;
                end else begin
                    err_q <= 1'b1;
                end
            end
            if (eng_done) begin
                busy_q <= 1'b0;
                if (cmd_q.wr) begin
                    err_q <= 1'b0;
                end else begin
                    rd_q  <= eng_rx;
                    err_q <= eng_ta_err;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CMD)
            bus_rdata = {busy_q, 4'b0, cmd_q.wr, cmd_q.phy, cmd_q.regn, cmd_q.wdata};
        else if (bus_addr == A_STAT)
            bus_rdata = {err_q, 15'b0, rd_q};
    end

    assign start_o = start_q;
    assign cmd_o   = cmd_q;
    assign busy_o  = busy_q;

    // R3: completion drops busy
    assert_busy_drops_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !busy_q);
    // R7: an out-of-range PHY is refused without a start
    assert_bad_phy_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !phy_ok) |=> (err_q && !busy_q && !start_q));
    // R9: a start only ever reaches an idle engine
    assert_start_only_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> eng_idle);
    // R10: a finished write keeps read data and clears the error
    assert_write_keeps_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && cmd_q.wr) |=> ($stable(rd_q) && !err_q));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_PHY  = 3,
    parameter int DIV_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    mdio_cmd_t   cmd;
    logic        start, busy, run, rise_stb, fall_stb;
    logic        eng_idle, eng_done, eng_ta_err;
    logic [15:0] eng_rx;

    mdio_mgmt_regs #(.ADDR_W(ADDR_W), .NUM_PHY(NUM_PHY)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_idle(eng_idle), .eng_done(eng_done), .eng_ta_err(eng_ta_err), .eng_rx(eng_rx),
        .start_o(start), .cmd_o(cmd), .busy_o(busy)
    );

    mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_in(mdio_in),
        .run(run), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .idle(eng_idle), .done(eng_done), .ta_err(eng_ta_err), .rx_data(eng_rx)
    );

    // R6: MDC only rises while the host sees busy
    assert_mdc_within_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);
    // R1: the output driver is off whenever no command is pending
    assert_oe_off_when_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
    localparam int DIV_HALF = 4;
    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_CMD  = 8'h14;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic mdc, mdio_out, mdio_oe;
    logic phy_drv = 1'b1;

    always #10 clk = ~clk;

    mdio_mgmt_master #(.ADDR_W(8), .NUM_PHY(3), .DIV_HALF(DIV_HALF)) i_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(phy_drv)
    );

    int vectors = 0, errors = 0, frames = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard of expected frames
    typedef struct {
        logic [63:0] bits;
        logic [63:0] mask;
        string       req;
    } exp_t;
    exp_t sbq[$];

    task automatic push_frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                              input logic [15:0] d);
        exp_t e;
        e.bits = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg,
                  wr ? 2'b10 : 2'b00, wr ? d : 16'h0};
        e.mask = wr ? 64'hFFFF_FFFF_FFFF_FFFF : ~64'h3FFFF;
        e.req  = wr ? "R4" : "R5";
        sbq.push_back(e);
    endtask

    // PHY responder and monitor
    int          rises = 0;
    logic [63:0] cap = '0, cap_oe = '0;
    logic [15:0] phy_word = 16'h0;
    logic        ta_val = 1'b0;

    always @(posedge mdc) begin
        cap[63 - rises]    = mdio_out;
        cap_oe[63 - rises] = mdio_oe;
        rises++;
        if (rises == 64) begin
            exp_t e;
            rises = 0;
            frames++;
            if (sbq.size() == 0) begin
                check("R9", 32'd1, 32'd0);
            end else begin
                e = sbq.pop_front();
                check(e.req, cap[63:32] & e.mask[63:32], e.bits[63:32] & e.mask[63:32]);
                check(e.req, cap[31:0] & e.mask[31:0], e.bits[31:0] & e.mask[31:0]);
                check(e.req, cap_oe[31:0], e.mask[31:0]);
            end
        end
    end

    always @(negedge mdc) begin
        #1;
        if (cap[29] && !cap[28] && rises == 47)
            phy_drv = ta_val;
        else if (cap[29] && !cap[28] && rises >= 48 && rises <= 63)
            phy_drv = phy_word[63 - rises];
        else
            phy_drv = 1'b1;
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 5000; i++) begin
            bus_read(A_CMD, d);
            if (!d[31]) return;
        end
        check("R3", 32'd1, 32'd0);
    endtask

    function automatic logic [31:0] cmd_word(input logic go, input logic wr, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] d);
        return {go, 4'b0, wr, phy, rg, d};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        int f0, n;
        repeat (3) @(negedge clk);
        // R1 reset state
        bus_read(A_CMD, d);  check("R1", d, 32'h0);
        bus_read(A_STAT, d); check("R1", d, 32'h0);
        check("R1", {30'd0, mdc, mdio_oe}, 32'h0);
        rst_n = 1'b1;
        // R2 unmapped offset
        bus_read(8'h00, d); check("R2", d, 32'h0);

        // R4 write frame, R3 busy, R6 MDC half period
        push_frame(1'b1, 5'd1, 5'd5, 16'hA5C3);
        bus_write(A_CMD, cmd_word(1'b1, 1'b1, 5'd1, 5'd5, 16'hA5C3));
        bus_read(A_CMD, d); check("R3", d, 32'h8425_A5C3);
        @(posedge mdc);
        n = 0;
        @(negedge clk);
        while (mdc) begin n++; @(negedge clk); end
        check("R6", n, DIV_HALF);
        wait_idle();
        bus_read(A_CMD, d);  check("R2", d, 32'h0425_A5C3);
        bus_read(A_STAT, d); check("R10", d, 32'h0);

        // R5 read from PHY 2, register 31
        phy_word = 16'h1234; ta_val = 1'b0;
        push_frame(1'b0, 5'd2, 5'd31, 16'h0);
        bus_write(A_CMD, cmd_word(1'b1, 1'b0, 5'd2, 5'd31, 16'h0));
        wait_idle();
        bus_read(A_STAT, d); check("R5", d, 32'h0000_1234);

        // R9 write while busy during a read
        phy_word = 16'hBEEF;
        f0 = frames;
        push_frame(1'b0, 5'd0, 5'd7, 16'h0);
        bus_write(A_CMD, cmd_word(1'b1, 1'b0, 5'd0, 5'd7, 16'h0));
        bus_write(A_CMD, cmd_word(1'b1, 1'b1, 5'd2, 5'd3, 16'h1111));
        bus_read(A_CMD, d); check("R9", d, 32'h8007_0000);
        wait_idle();
        repeat (600) @(negedge clk);
        check("R9", frames - f0, 32'd1);
        bus_read(A_STAT, d); check("R9", d, 32'h0000_BEEF);

        // R8 turnaround error, then R10 write clears flag and keeps data
        phy_word = 16'h0F0F; ta_val = 1'b1;
        push_frame(1'b0, 5'd1, 5'd2, 16'h0);
        bus_write(A_CMD, cmd_word(1'b1, 1'b0, 5'd1, 5'd2, 16'h0));
        wait_idle();
        bus_read(A_STAT, d); check("R8", d, 32'h8000_0F0F);
        ta_val = 1'b0;
        push_frame(1'b1, 5'd1, 5'd2, 16'h5555);
        bus_write(A_CMD, cmd_word(1'b1, 1'b1, 5'd1, 5'd2, 16'h5555));
        wait_idle();
        bus_read(A_STAT, d); check("R10", d, 32'h0000_0F0F);

        // R7 out-of-range PHY numbers
        f0 = frames;
        bus_write(A_CMD, cmd_word(1'b1, 1'b0, 5'd3, 5'd1, 16'h0));
        bus_read(A_CMD, d);  check("R7", {31'd0, d[31]}, 32'h0);
        bus_read(A_STAT, d); check("R7", d, 32'h8000_0F0F);
        bus_write(A_CMD, cmd_word(1'b1, 1'b1, 5'd31, 5'd1, 16'h7777));
        repeat (600) @(negedge clk);
        check("R7", {31'd0, mdc}, 32'h0);
        check("R7", frames - f0, 32'd0);

        // R3 command without go has no effect
        bus_write(A_CMD, cmd_word(1'b0, 1'b1, 5'd2, 5'd9, 16'h0001));
        repeat (600) @(negedge clk);
        check("R3", frames - f0, 32'd0);
        bus_read(A_CMD, d); check("R3", d, 32'h0422_5555);

        check("R4", sbq.size(), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule